// File: doc/BRIEF.md
# Watchdog Timer with Protected Configuration

This block supervises software by counting pulses from a slow oscillator tick (about 128 kHz). The tick arrives as a one-cycle strobe in the fast clock domain. If software does not restart the count with a kick strobe before the count reaches a time-out it has chosen, the block acts. Depending on two enable bits, it raises a latched interrupt request, emits a one-cycle system reset pulse, or first interrupts and then falls back to reset-only operation so that the next expiry resets the system.

Software sees one 8-bit control word. Bit 0 is the interrupt flag, cleared by writing 1. Bit 1 is the interrupt enable. Bit 2 is the reset enable. Bit 3 is the change-unlock bit. Bits 7:4 select the time-out. Software can set the reset enable at any time. Clearing it, or changing the time-out select, takes two steps. The first is an unlock write with bits 3 and 2 both at 1. The second is a write with bit 3 at 0, made during the four cycles that follow. A lock input, standing for a programmed fuse, pins the block to reset-only operation.

Top module: `wdt_guard`

## Requirements
- R1: A kick strobe clears the count. If the block is kicked more often than its time-out, it never fires.
- R2: The time-out is 2^(BASE_LOG2+S) oscillator ticks, where S is the select field (bits 7:4). Only cycles with osc_tick high advance the count. The count also restarts after each expiry.
- R3: Select values 10 to 15 give the same time-out as value 9. The field still reads back the value that was written.
- R4: In interrupt mode (bit 1 = 1, bit 2 = 0), expiry sets the flag (bit 0) and drives irq high. No reset pulse is produced.
- R5: In reset mode (bit 1 = 0, bit 2 = 1), expiry produces rst_pulse for exactly one cycle, in the cycle after the expiring tick.
- R6: In combined mode (bits 1 and 2 both 1), the first expiry sets the flag and clears the interrupt enable. The next expiry then produces a reset pulse.
- R7: irq follows the flag. Writing 1 to bit 0 clears the flag. Writing 0 to bit 0 leaves it set.
- R8: While lock_fuse is 1, bit 2 reads 1 and bit 1 reads 0 whatever is written, and every expiry produces a reset pulse.
- R9: A write that has bit 2 at 1 always sets the reset enable. Outside the unlock window, a write cannot clear bit 2 or change bits 7:4.
- R10: A write with bits 3 and 2 both at 1 is an unlock write. It sets the reset enable, and bit 3 then reads 1 for exactly four cycles before clearing itself.
- R11: While bit 3 reads 1, a write with bit 3 at 0 loads bit 2 and bits 7:4 from the written data and ends the window. After the window closes, such a write leaves bit 2 set and bits 7:4 unchanged.
- R12: After a synchronous reset, rd_data is 0, irq is 0 and rst_pulse is 0. If lock_fuse is high, bit 2 reads 1 instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | One-cycle strobe per slow oscillator period |
| lock_fuse | input | 1 | Forces reset-only operation when high |
| kick | input | 1 | Restart strobe from software |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 8 | Control word to write |
| rd_data | output | 8 | Current control word as software sees it |
| irq | output | 1 | Interrupt request (level, equal to the flag) |
| rst_pulse | output | 1 | One-cycle system reset request |

## Verification
The hardest state to reach from the ports is the narrow unlock window. A protected write counts only if it lands inside the four cycles after an unlock write, so the bench places writes at exact cycle offsets. It probes bit 3 in each cycle of the window and again the cycle after it closes. It makes one protected write inside the window and another after it closes. A second hard case is combined mode, where the mode change is driven by hardware. After the first expiry the bench leaves the block un-kicked and measures the cycle distance to the reset pulse that follows. A tick pattern that alternates each cycle, started at a known phase, shows that only ticks advance the count.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    // Control word as software sees it (bit positions are part of the interface)
    typedef struct packed {
        logic [3:0] sel;    // time-out select
        logic       chg;    // change-unlock window open
        logic       re;     // reset enable
        logic       ie;     // interrupt enable
        logic       flag;   // interrupt flag, write 1 to clear
    } wdt_reg_t;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'b00,
        MODE_IRQ  = 2'b01,
        MODE_RST  = 2'b10,
        MODE_BOTH = 2'b11
    } wdt_mode_t;

    function automatic wdt_mode_t mode_of(input logic ie, input logic re);
        return wdt_mode_t'({re, ie});
    endfunction

    function automatic logic [3:0] clip_sel(input logic [3:0] s, input int max_sel);
        return (int'(s) > max_sel) ? 4'(max_sel) : s;
    endfunction

endpackage

// File: rtl/wdt_timer.sv
module wdt_timer
    import wdt_pkg::*;
#(
    parameter int BASE_LOG2 = 11,
    parameter int MAX_SEL   = 9
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       kick,
    input  logic [3:0] sel,
    output logic       expire
);
    localparam int CW = BASE_LOG2 + MAX_SEL;

    logic [CW-1:0] cnt_q;
    logic [CW:0]   span;
    logic [CW-1:0] last;

    always_comb begin
        span   = (CW+1)'(1) << (BASE_LOG2 + int'(clip_sel(sel, MAX_SEL)));
        last   = CW'(span - 1'b1);
        expire = tick && !kick && (cnt_q >= last);
    end

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (kick) cnt_q <= '0;
        else if (tick) cnt_q <= expire ? '0 : cnt_q + 1'b1;
    end

    // R1
    kick_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        kick |=> !expire);

endmodule

// File: rtl/wdt_action.sv
module wdt_action
    import wdt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic expire,
    input  logic ie,
    input  logic re,
    output logic flag_set,
    output logic ie_clr,
    output logic rst_pulse
);
    wdt_mode_t mode;

    always_comb begin
        mode     = mode_of(ie, re);
        flag_set = expire && (mode == MODE_IRQ || mode == MODE_BOTH);
        ie_clr   = expire && (mode == MODE_BOTH);
    end

    always_ff @(posedge clk) begin
        if (rst) rst_pulse <= 1'b0;
        else     rst_pulse <= expire && (mode == MODE_RST);
    end

    // R5
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rst_pulse |=> !rst_pulse);

endmodule

// File: rtl/wdt_cfg.sv
module wdt_cfg
    import wdt_pkg::*;
#(
    parameter int UNLOCK_WIN = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     lock,
    input  logic     wr_en,
    input  wdt_reg_t wr_data,
    input  logic     hw_flag_set,
    input  logic     hw_ie_clr,
    output wdt_reg_t view
);
    localparam int WW = $clog2(UNLOCK_WIN + 1);

    logic          flag_q, ie_q, re_q;
    logic [3:0]    sel_q;
    logic [WW-1:0] win_q;
    logic          chg_active, unlock, prot;

    always_comb begin
        chg_active = (win_q != '0);
        unlock     = wr_en && wr_data.chg && wr_data.re;
        prot       = wr_en && chg_active && !wr_data.chg;
        view.sel   = sel_q;
        view.chg   = chg_active;
        view.re    = re_q | lock;
        view.ie    = ie_q & ~lock;
        view.flag  = flag_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            ie_q   <= 1'b0;
            re_q   <= 1'b0;
            sel_q  <= '0;
            win_q  <= '0;
        end else begin
            if (hw_flag_set)               flag_q <= 1'b1;
            else if (wr_en && wr_data.flag) flag_q <= 1'b0;

            if (hw_ie_clr)  ie_q <= 1'b0;
            else if (wr_en) ie_q <= wr_data.ie;

            if (unlock) begin
                win_q <= WW'(UNLOCK_WIN);
                re_q  <= 1'b1;
            end else if (prot) begin
                re_q  <= wr_data.re;
                sel_q <= wr_data.sel;
                win_q <= '0;
            end else begin
                if (wr_en && wr_data.re) re_q <= 1'b1;
                if (chg_active)          win_q <= win_q - 1'b1;
            end
        end
    end

    // R11
    sel_guard_chk: assert property (@(posedge clk) disable iff (rst)
        !chg_active |=> $stable(sel_q));

    // R9
    re_guard_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(re_q) |-> $past(chg_active));

    // R10
    win_open_chk: assert property (@(posedge clk) disable iff (rst)
        (chg_active && !$past(chg_active)) |-> $past(wr_en && wr_data.chg && wr_data.re));

    // R6
    hw_ie_clear_chk: assert property (@(posedge clk) disable iff (rst)
        hw_ie_clr |=> !ie_q);

endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
    import wdt_pkg::*;
#(
    parameter int BASE_LOG2  = 11,
    parameter int MAX_SEL    = 9,
    parameter int UNLOCK_WIN = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       osc_tick,
    input  logic       lock_fuse,
    input  logic       kick,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic       irq,
    output logic       rst_pulse
);
    wdt_reg_t view;
    wdt_reg_t wr_word;
    logic     expire, flag_set, ie_clr;

    assign wr_word = wdt_reg_t'(wr_data);

    wdt_cfg #(.UNLOCK_WIN(UNLOCK_WIN)) u_cfg (
        .clk         (clk),
        .rst         (rst),
        .lock        (lock_fuse),
        .wr_en       (wr_en),
        .wr_data     (wr_word),
        .hw_flag_set (flag_set),
        .hw_ie_clr   (ie_clr),
        .view        (view)
    );

    wdt_timer #(.BASE_LOG2(BASE_LOG2), .MAX_SEL(MAX_SEL)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .tick   (osc_tick),
        .kick   (kick),
        .sel    (view.sel),
        .expire (expire)
    );

    wdt_action u_action (
        .clk       (clk),
        .rst       (rst),
        .expire    (expire),
        .ie        (view.ie),
        .re        (view.re),
        .flag_set  (flag_set),
        .ie_clr    (ie_clr),
        .rst_pulse (rst_pulse)
    );

    assign rd_data = view;
    assign irq     = view.flag;

    // R8
    lock_reset_chk: assert property (@(posedge clk) disable iff (rst)
        (lock_fuse && expire) |=> rst_pulse);

    // R4
    irq_no_reset_chk: assert property (@(posedge clk) disable iff (rst)
        (expire && view.ie && !view.re) |=> (irq && !rst_pulse));

endmodule

// File: tb/sim_wdt_guard.sv
module sim_wdt_guard;
    localparam int B   = 4;
    localparam int WIN = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       osc_tick = 1'b1;
    logic       lock_fuse = 1'b0;
    logic       kick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       irq, rst_pulse;

    int  n_run = 0, n_fail = 0, cyc = 0, rst_seen = 0;
    bit  tick_alt = 1'b0;
    bit  done = 1'b0;

    // reference model state
    int         m_cnt = 0, m_win = 0;
    bit         m_flag = 0, m_ie = 0, m_re = 0, m_rst = 0;
    logic [3:0] m_sel = 4'd0;

    wdt_guard #(.BASE_LOG2(B), .MAX_SEL(9), .UNLOCK_WIN(WIN)) u0 (
        .clk(clk), .rst(rst), .osc_tick(osc_tick), .lock_fuse(lock_fuse),
        .kick(kick), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .irq(irq), .rst_pulse(rst_pulse)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (rst) begin
            m_cnt = 0; m_win = 0; m_flag = 0; m_ie = 0; m_re = 0; m_rst = 0; m_sel = 4'd0;
        end else begin
            bit eie, ere, exp_now, chg;
            int s, lim;
            eie = m_ie && !lock_fuse;
            ere = m_re || lock_fuse;
            s   = (int'(m_sel) > 9) ? 9 : int'(m_sel);
            lim = 1 << (B + s);
            exp_now = !kick && osc_tick && (m_cnt >= lim - 1);
            chg = (m_win != 0);
            if (kick) m_cnt = 0;
            else if (osc_tick) m_cnt = exp_now ? 0 : m_cnt + 1;
            m_rst = exp_now && ere && !eie;
            if (exp_now && eie) m_flag = 1;
            else if (wr_en && wr_data[0]) m_flag = 0;
            if (exp_now && eie && ere) m_ie = 0;
            else if (wr_en) m_ie = wr_data[1];
            if (wr_en && wr_data[3] && wr_data[2]) begin
                m_win = WIN; m_re = 1;
            end else if (wr_en && chg && !wr_data[3]) begin
                m_re = wr_data[2]; m_sel = wr_data[7:4]; m_win = 0;
            end else begin
                if (wr_en && wr_data[2]) m_re = 1;
                if (m_win != 0) m_win = m_win - 1;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        logic [7:0] erd;
        @(negedge clk);
        erd = {m_sel, (m_win != 0), (m_re || lock_fuse), (m_ie && !lock_fuse), m_flag};
        if (!rst) begin
            chk(rd_data == erd, "R9 rd_data per-cycle", rd_data, erd);
            chk(irq == m_flag, "R4 irq per-cycle", irq, m_flag);
            chk(rst_pulse == m_rst, "R5 rst_pulse per-cycle", rst_pulse, m_rst);
        end
        if (rst_pulse) rst_seen++;
        osc_tick = tick_alt ? ~osc_tick : 1'b1;
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        step();
        wr_en = 1'b0; wr_data = 8'h00;
    endtask

    task automatic wait_evt(input bit want_irq, output int n);
        n = 0;
        do begin
            step();
            n++;
        end while (!(want_irq ? irq : rst_pulse) && n < 20000);
    endtask

    task automatic kick_wait(input bit want_irq, output int n);
        kick = 1'b1;
        if (tick_alt) osc_tick = 1'b0;
        step();
        kick = 1'b0;
        wait_evt(want_irq, n);
    endtask

    initial begin
        int n, r0;
        repeat (3) step();
        rst = 1'b0;
        step();
        // R12 reset state
        chk(rd_data == 8'h00, "R12 rd after reset", rd_data, 0);
        chk(irq == 1'b0, "R12 irq after reset", irq, 0);

        // R9 reset enable can be set freely; reset mode time-out (R2, R5)
        wr(8'h04);
        chk(rd_data[2] == 1'b1, "R9 set re without unlock", rd_data[2], 1);
        r0 = rst_seen;
        kick_wait(1'b0, n);
        chk(n == 16, "R2 time-out sel0", n, 16);
        chk(irq == 1'b0, "R5 no irq in reset mode", irq, 0);
        step();
        chk(rst_pulse == 1'b0, "R5 pulse one cycle", rst_pulse, 0);

        // R1 regular kicks keep it quiet
        r0 = rst_seen;
        for (int k = 0; k < 6; k++) begin
            kick = 1'b1; step(); kick = 1'b0;
            repeat (9) step();
        end
        chk(rst_seen == r0, "R1 no pulse while kicked", rst_seen - r0, 0);

        // R2 only ticks advance the count
        tick_alt = 1'b1;
        kick_wait(1'b0, n);
        chk(n == 31, "R2 alternating ticks", n, 31);
        tick_alt = 1'b0;
        osc_tick = 1'b1;

        // R9 protected fields without unlock
        wr(8'h00);
        chk(rd_data[2] == 1'b1, "R9 re not cleared", rd_data[2], 1);
        wr(8'h14);
        chk(rd_data[7:4] == 4'd0, "R9 sel not changed", rd_data[7:4], 0);

        // R10 unlock window lasts four cycles
        wr(8'h0C);
        chk(rd_data[3] == 1'b1, "R10 chg open", rd_data[3], 1);
        for (int k = 0; k < 3; k++) begin
            step();
            chk(rd_data[3] == 1'b1, "R10 chg held", rd_data[3], 1);
        end
        step();
        chk(rd_data[3] == 1'b0, "R10 chg self-clear", rd_data[3], 0);
        // R11 late protected write ignored
        wr(8'h30);
        chk(rd_data[7:4] == 4'd0, "R11 late write sel", rd_data[7:4], 0);
        chk(rd_data[2] == 1'b1, "R11 late write re", rd_data[2], 1);

        // R11 timely protected write -> interrupt mode, sel 1
        wr(8'h0C);
        step();
        wr(8'h12);
        chk((rd_data & 8'hFE) == 8'h12, "R11 protected write applied", rd_data & 8'hFE, 8'h12);

        // R4 interrupt mode
        r0 = rst_seen;
        kick_wait(1'b1, n);
        chk(n == 32, "R4 irq time-out sel1", n, 32);
        chk(rd_data[0] == 1'b1, "R4 flag set", rd_data[0], 1);
        chk(rst_seen == r0, "R4 no reset", rst_seen - r0, 0);

        // R7 flag clear semantics
        wr(8'h02);
        chk(irq == 1'b1, "R7 write 0 keeps flag", irq, 1);
        wr(8'h03);
        chk(irq == 1'b0, "R7 write 1 clears flag", irq, 0);

        // R6 combined mode
        wr(8'h06);
        r0 = rst_seen;
        kick_wait(1'b1, n);
        chk(n == 32, "R6 first expiry irq", n, 32);
        chk(rd_data[1] == 1'b0, "R6 ie cleared by hw", rd_data[1], 0);
        chk(rst_seen == r0, "R6 no reset at first expiry", rst_seen - r0, 0);
        wait_evt(1'b0, n);
        chk(n == 32, "R6 second expiry reset", n, 32);

        // R3 reserved select behaves as 9
        wr(8'h05);
        wr(8'h0C);
        wr(8'hC4);
        chk(rd_data[7:4] == 4'd12, "R3 sel reads back", rd_data[7:4], 12);
        kick_wait(1'b0, n);
        chk(n == 8192, "R3 reserved time-out", n, 8192);

        // R8 lock forces reset-only
        lock_fuse = 1'b1;
        step();
        chk(rd_data[2:1] == 2'b10, "R8 lock view", rd_data[2:1], 2);
        wr(8'h02);
        chk(rd_data[1] == 1'b0, "R8 ie stays 0", rd_data[1], 0);
        wr(8'h0C);
        wr(8'h00);
        chk(rd_data[2] == 1'b1, "R8 re stays 1", rd_data[2], 1);
        kick_wait(1'b0, n);
        chk(n == 16, "R8 locked reset time-out", n, 16);
        chk(irq == 1'b0, "R8 no irq when locked", irq, 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        wait (cyc > 100000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 100000);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule